// File: doc/BRIEF.md
# Per-Bit Attribute Control/Status Register Bank with AXI4-Lite Access

This block is an AXI4-Lite slave holding a small set of 32-bit control and status registers. Every bit of every register carries one of six access behaviours: plain read-only, plain read-write, sticky status cleared by writing 1, sticky status cleared whole by any write, hidden status cleared by writing 1, and hidden control set by writing 1. The attribute of each bit and each register's reset value are fixed by parameters of the top module. The defaults are computed by functions in the package.

Address bit 28 splits the register space into two regions of four registers each. Bit 28 clear selects the primary region and bit 28 set selects the secondary region. Within a region, address bits [3:2] pick the register. Address bits [27:4] must be zero for a register to be hit. Bits [1:0] and every bit above 28 are ignored, because the block filters no base address.

On the hardware side, `hw_evt` raises status bits and clears hidden-control bits. `hw_ro` supplies the value of read-only bits. `reg_q` exposes every stored bit, and it shows 0 in read-only positions.

Top module: `regbank_axil`

## Requirements
- R1: Address bit 28 selects the region. Register g = 4*addr[28] + addr[3:2]. g0..g3 form the primary region and g4..g7 form the secondary region. The two regions hold independent state.
- R2: Address bits 31:29 and 1:0 do not take part in decode. Any address is accepted, and an address that differs only in those bits reaches the same register.
- R3: After reset, every stored bit takes its default value. g0=0x000000A5, g1=0, g2=0x00000001, g3=0x5A5A000C, g4=0x00001234, g5=0, g6=0, g7=0x000000FF. On `reg_q`, read-only positions show 0.
- R4: Read-only bits ignore every write and read back the current `hw_ro` value. By default, g5 is all read-only and g1[31:16] is read-only.
- R5: A write-1-clear status bit reads back its state. `hw_evt` sets it. A written 1 clears it, and a written 0 leaves it unchanged. By default these are g1[15:0].
- R6: In a clear-on-any-write register (all of g2 by default), `hw_evt` sets bits. Any write to the register clears all of its bits in the enabled byte lanes, whatever the data.
- R7: A hidden write-1-clear bit always reads as 0. Its state is visible on `reg_q`. `hw_evt` sets it, a written 1 clears it, and a written 0 has no effect. By default these are all of g7 and g3[7:0].
- R8: A hidden write-1-set bit always reads as 0. A written 1 sets it and a written 0 has no effect. An `hw_evt` pulse clears it when no software set is present. By default these are all of g6 and g3[15:8].
- R9: When `hw_evt` and a software clear reach a status bit in the same cycle, the bit ends up 1.
- R10: Write strobes act per byte lane. Strobe bit k covers data bits [8k+7:8k]. No bit outside an enabled lane changes.
- R11: The write address and write data may arrive in either order or together. Exactly one write response is returned, with code OKAY (2'b00), and only after both have been taken.
- R12: An address with a nonzero bit in [27:4] maps to no register. A read of it returns 0, a write to it changes nothing, and both respond OKAY.
- R13: A raised `s_bvalid` or `s_rvalid` stays high until its ready is seen. `s_rdata` stays stable while `s_rvalid` waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awaddr | input | 32 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response code |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 32 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| hw_evt | input | 8x32 | Per-bit hardware set for status bits and hardware clear for hidden-set bits |
| hw_ro | input | 8x32 | Per-bit values of read-only bits |
| reg_q | output | 8x32 | Stored state of every register bit |

## Verification
The bench writes to a register in one region and reads the same offset in the other region. A decoder that ignored bit 28 would alias the two regions and return the last value written. It also reaches registers through addresses with high bits set and through undefined offsets. Base filtering would drop those writes, and a loose decoder would let a stray write corrupt a register. The hidden set and clear bits are compared both on the read bus, where they must read zero, and on `reg_q`, where a design returning stored state on reads or treating a written 0 as an action would disagree. Writes are also issued with address first, data first, with partial strobes, and while a hardware event is held on the same bit. These catch a lost response, a whole-word update, or a clear that outranks a set.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    localparam int DATA_W          = 32;
    localparam int LANE_W          = 8;
    localparam int STRB_W          = DATA_W / LANE_W;
    localparam int ADDR_W          = 32;
    localparam int SEL_BIT         = 28;
    localparam int REGS_PER_REGION = 4;
    localparam int IDX_W           = $clog2(REGS_PER_REGION);
    localparam int NUM_REGS        = 2 * REGS_PER_REGION;
    localparam int GIDX_W          = IDX_W + 1;
    localparam int WORD_LSB        = $clog2(STRB_W);

    typedef enum logic [2:0] {
        ATTR_RO   = 3'd0,
        ATTR_RW   = 3'd1,
        ATTR_RW1C = 3'd2,
        ATTR_RWC  = 3'd3,
        ATTR_W1C  = 3'd4,
        ATTR_W1S  = 3'd5
    } attr_e;

    typedef logic [NUM_REGS-1:0][DATA_W-1:0][2:0] attr_map_t;
    typedef logic [NUM_REGS-1:0][DATA_W-1:0]      word_arr_t;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [STRB_W-1:0] strb;
    } wr_req_t;

    typedef struct packed {
        logic              hit;
        logic [GIDX_W-1:0] idx;
    } dec_t;

    function automatic dec_t decode(input logic [ADDR_W-1:0] a);
        dec_t d;
        d.idx = {a[SEL_BIT], a[WORD_LSB +: IDX_W]};
        d.hit = (a[SEL_BIT-1:WORD_LSB+IDX_W] == '0);
        return d;
    endfunction

    function automatic attr_e attr_of(input int g, input int b);
        case (g)
            0:       return ATTR_RW;
            1:       return (b < 16) ? ATTR_RW1C : ATTR_RO;
            2:       return ATTR_RWC;
            3:       return (b < 8) ? ATTR_W1C : ((b < 16) ? ATTR_W1S : ATTR_RW);
            4:       return ATTR_RW;
            5:       return ATTR_RO;
            6:       return ATTR_W1S;
            default: return ATTR_W1C;
        endcase
    endfunction

    function automatic attr_map_t default_attrs();
        attr_map_t m;
        for (int g = 0; g < NUM_REGS; g++) begin
            for (int b = 0; b < DATA_W; b++) begin
                m[g][b] = attr_of(g, b);
            end
        end
        return m;
    endfunction

    function automatic word_arr_t default_resets();
        word_arr_t r;
        r    = '0;
        r[0] = 32'h0000_00A5;
        r[2] = 32'h0000_0001;
        r[3] = 32'h5A5A_000C;
        r[4] = 32'h0000_1234;
        r[7] = 32'h0000_00FF;
        return r;
    endfunction

    function automatic word_arr_t stored_mask(input attr_map_t m);
        word_arr_t k;
        for (int g = 0; g < NUM_REGS; g++) begin
            for (int b = 0; b < DATA_W; b++) begin
                k[g][b] = (m[g][b] != ATTR_RO);
            end
        end
        return k;
    endfunction

endpackage

// File: rtl/regbank_wr_port.sv
module regbank_wr_port
    import regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] wstrb,
    input  logic              wvalid,
    output logic              wready,
    output logic [1:0]        bresp,
    output logic              bvalid,
    input  logic              bready,
    output wr_req_t           req
);

    logic              aw_held, w_held;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [STRB_W-1:0] strb_q;
    logic              commit;

    assign awready = !aw_held && !bvalid;
    assign wready  = !w_held && !bvalid;
    assign commit  = aw_held && w_held;
    assign bresp   = 2'b00;

    always_ff @(posedge clk) begin
        if (rst) begin
            aw_held <= 1'b0;
            w_held  <= 1'b0;
            bvalid  <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
            strb_q  <= '0;
        end else begin
            if (awvalid && awready) begin
                aw_held <= 1'b1;
                addr_q  <= awaddr;
            end
            if (wvalid && wready) begin
                w_held <= 1'b1;
                data_q <= wdata;
                strb_q <= wstrb;
            end
            if (commit) begin
                aw_held <= 1'b0;
                w_held  <= 1'b0;
                bvalid  <= 1'b1;
            end else if (bvalid && bready) begin
                bvalid <= 1'b0;
            end
        end
    end

    always_comb begin
        req.vld  = commit;
        req.addr = addr_q;
        req.data = data_q;
        req.strb = strb_q;
    end

endmodule

// File: rtl/regbank_rd_port.sv
module regbank_rd_port
    import regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] araddr,
    input  logic              arvalid,
    output logic              arready,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        rresp,
    output logic              rvalid,
    input  logic              rready,
    input  word_arr_t         rd_words
);

    dec_t              rdec;
    logic [DATA_W-1:0] sel_word;
    logic              unused_rd_addr;

    assign rdec           = decode(araddr);
    assign sel_word       = rdec.hit ? rd_words[rdec.idx] : '0;
    assign arready        = !rvalid;
    assign rresp          = 2'b00;
    assign unused_rd_addr = ^{araddr[ADDR_W-1:SEL_BIT+1], araddr[WORD_LSB-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else if (arvalid && arready) begin
            rvalid <= 1'b1;
            rdata  <= sel_word;
        end else if (rvalid && rready) begin
            rvalid <= 1'b0;
        end
    end

endmodule

// File: rtl/regbank_cell.sv
module regbank_cell
    import regbank_pkg::*;
#(
    parameter logic [DATA_W-1:0][2:0] ATTR = '0,
    parameter logic [DATA_W-1:0]      RST  = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] wstrb,
    input  logic [DATA_W-1:0] hw_evt,
    input  logic [DATA_W-1:0] hw_ro,
    output logic [DATA_W-1:0] q,
    output logic [DATA_W-1:0] rd
);

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        logic lane_we;
        assign lane_we = we && wstrb[b / LANE_W];

        if (ATTR[b] == ATTR_RO) begin : g_ro
            logic unused_ro;
            assign unused_ro = ^{lane_we, wdata[b], hw_evt[b]};
            assign q[b]  = 1'b0;
            assign rd[b] = hw_ro[b];
        end else if (ATTR[b] == ATTR_RW) begin : g_rw
            logic st, unused_rw;
            assign unused_rw = ^{hw_evt[b], hw_ro[b]};
            always_ff @(posedge clk) begin
                if (rst)          st <= RST[b];
                else if (lane_we) st <= wdata[b];
            end
            assign q[b]  = st;
            assign rd[b] = st;
        end else if (ATTR[b] == ATTR_RWC) begin : g_rwc
            logic st, unused_rwc;
            assign unused_rwc = ^{wdata[b], hw_ro[b]};
            always_ff @(posedge clk) begin
                if (rst)            st <= RST[b];
                else if (hw_evt[b]) st <= 1'b1;
                else if (lane_we)   st <= 1'b0;
            end
            assign q[b]  = st;
            assign rd[b] = st;
        end else if (ATTR[b] == ATTR_W1S) begin : g_w1s
            logic st, unused_w1s;
            assign unused_w1s = hw_ro[b];
            always_ff @(posedge clk) begin
                if (rst)                      st <= RST[b];
                else if (lane_we && wdata[b]) st <= 1'b1;
                else if (hw_evt[b])           st <= 1'b0;
            end
            assign q[b]  = st;
            assign rd[b] = 1'b0;
        end else begin : g_clr
            logic st, unused_clr;
            assign unused_clr = hw_ro[b];
            always_ff @(posedge clk) begin
                if (rst)                      st <= RST[b];
                else if (hw_evt[b])           st <= 1'b1;
                else if (lane_we && wdata[b]) st <= 1'b0;
            end
            assign q[b]  = st;
            assign rd[b] = (ATTR[b] == ATTR_RW1C) ? st : 1'b0;
        end
    end

endmodule

// File: rtl/regbank_axil.sv
module regbank_axil
    import regbank_pkg::*;
#(
    parameter attr_map_t ATTR_MAP = default_attrs(),
    parameter word_arr_t RST_VAL  = default_resets()
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [DATA_W-1:0] s_wdata,
    input  logic [STRB_W-1:0] s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [ADDR_W-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [DATA_W-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    input  word_arr_t         hw_evt,
    input  word_arr_t         hw_ro,
    output word_arr_t         reg_q
);

    wr_req_t   wreq;
    dec_t      wdec;
    word_arr_t rd_words;
    logic      unused_wr_addr;

    assign wdec           = decode(wreq.addr);
    assign unused_wr_addr = ^{wreq.addr[ADDR_W-1:SEL_BIT+1], wreq.addr[WORD_LSB-1:0]};

    regbank_wr_port u_wr (
        .clk     (clk),
        .rst     (rst),
        .awaddr  (s_awaddr),
        .awvalid (s_awvalid),
        .awready (s_awready),
        .wdata   (s_wdata),
        .wstrb   (s_wstrb),
        .wvalid  (s_wvalid),
        .wready  (s_wready),
        .bresp   (s_bresp),
        .bvalid  (s_bvalid),
        .bready  (s_bready),
        .req     (wreq)
    );

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic sel_we;
        assign sel_we = wreq.vld && wdec.hit && (wdec.idx == GIDX_W'(g));

        regbank_cell #(
            .ATTR (ATTR_MAP[g]),
            .RST  (RST_VAL[g])
        ) u_cell (
            .clk    (clk),
            .rst    (rst),
            .we     (sel_we),
            .wdata  (wreq.data),
            .wstrb  (wreq.strb),
            .hw_evt (hw_evt[g]),
            .hw_ro  (hw_ro[g]),
            .q      (reg_q[g]),
            .rd     (rd_words[g])
        );
    end

    regbank_rd_port u_rd (
        .clk      (clk),
        .rst      (rst),
        .araddr   (s_araddr),
        .arvalid  (s_arvalid),
        .arready  (s_arready),
        .rdata    (s_rdata),
        .rresp    (s_rresp),
        .rvalid   (s_rvalid),
        .rready   (s_rready),
        .rd_words (rd_words)
    );

endmodule

// File: rtl/regbank_axil_chk.sv
module regbank_axil_chk
    import regbank_pkg::*;
#(
    parameter attr_map_t ATTR_MAP = default_attrs(),
    parameter word_arr_t RST_VAL  = default_resets()
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        s_bresp,
    input logic              s_bvalid,
    input logic              s_bready,
    input logic [DATA_W-1:0] s_rdata,
    input logic [1:0]        s_rresp,
    input logic              s_rvalid,
    input logic              s_rready,
    input word_arr_t         hw_evt,
    input word_arr_t         reg_q
);

    localparam word_arr_t KEEP = stored_mask(ATTR_MAP);

    // R3: first cycle out of reset shows the default stored values
    p_reset_defaults_r3: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (reg_q == (RST_VAL & KEEP)));

    // R11: write responses are always OKAY
    p_bresp_okay_r11: assert property (@(posedge clk) disable iff (rst)
        s_bvalid |-> (s_bresp == 2'b00));

    // R12: read responses are always OKAY, mapped or not
    p_rresp_okay_r12: assert property (@(posedge clk) disable iff (rst)
        s_rvalid |-> (s_rresp == 2'b00));

    // R13: response valids hold until accepted
    p_bvalid_hold_r13: assert property (@(posedge clk) disable iff (rst)
        (s_bvalid && !s_bready) |=> s_bvalid);

    p_rdata_hold_r13: assert property (@(posedge clk) disable iff (rst)
        (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata)));

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_r
        for (genvar b = 0; b < DATA_W; b++) begin : g_b
            if (ATTR_MAP[g][b] == ATTR_RW1C || ATTR_MAP[g][b] == ATTR_RWC ||
                ATTR_MAP[g][b] == ATTR_W1C) begin : g_st
                // R9: a hardware event always leaves the status bit set
                p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
                    hw_evt[g][b] |=> reg_q[g][b]);
            end else if (ATTR_MAP[g][b] == ATTR_W1S) begin : g_ws
                // R8: a set control bit only drops on a hardware clear
                p_w1s_hold_r8: assert property (@(posedge clk) disable iff (rst)
                    (reg_q[g][b] && !hw_evt[g][b]) |=> reg_q[g][b]);
            end
        end
    end

endmodule

bind regbank_axil regbank_axil_chk #(
    .ATTR_MAP (ATTR_MAP),
    .RST_VAL  (RST_VAL)
) u_chk (.*);

// File: tb/regbank_axil_test.sv
module regbank_axil_test;
    import regbank_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam logic [31:0] SEC = 32'h1000_0000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] s_awaddr = '0;
    logic              s_awvalid = 1'b0;
    logic              s_awready;
    logic [DATA_W-1:0] s_wdata = '0;
    logic [STRB_W-1:0] s_wstrb = '0;
    logic              s_wvalid = 1'b0;
    logic              s_wready;
    logic [1:0]        s_bresp;
    logic              s_bvalid;
    logic              s_bready = 1'b1;
    logic [ADDR_W-1:0] s_araddr = '0;
    logic              s_arvalid = 1'b0;
    logic              s_arready;
    logic [DATA_W-1:0] s_rdata;
    logic [1:0]        s_rresp;
    logic              s_rvalid;
    logic              s_rready = 1'b1;
    word_arr_t         hw_evt = '0;
    word_arr_t         hw_ro = '0;
    word_arr_t         reg_q;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    regbank_axil uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    // order: 0 both together, 1 address before data, 2 data before address
    task automatic axi_wr(input logic [31:0] a, input logic [31:0] d,
                          input logic [3:0] st, input int order);
        bit aw_done = 0, w_done = 0, aw_hs, w_hs;
        @(negedge clk);
        while (!(aw_done && w_done)) begin
            s_awaddr  = a;
            s_wdata   = d;
            s_wstrb   = st;
            s_awvalid = !aw_done && (order != 2 || w_done);
            s_wvalid  = !w_done && (order != 1 || aw_done);
            aw_hs = s_awvalid && s_awready;
            w_hs  = s_wvalid && s_wready;
            @(posedge clk);
            aw_done |= aw_hs;
            w_done  |= w_hs;
            @(negedge clk);
        end
        s_awvalid = 1'b0;
        s_wvalid  = 1'b0;
        while (!s_bvalid) @(negedge clk);
        check("R11 bresp", {30'd0, s_bresp}, 32'd0);
    endtask

    task automatic axi_rd(input logic [31:0] a, output logic [31:0] d);
        bit hs = 0;
        @(negedge clk);
        while (!hs) begin
            s_araddr  = a;
            s_arvalid = 1'b1;
            hs = s_arready;
            @(posedge clk);
            @(negedge clk);
        end
        s_arvalid = 1'b0;
        while (!s_rvalid) @(negedge clk);
        d = s_rdata;
        check("R12 rresp", {30'd0, s_rresp}, 32'd0);
    endtask

    task automatic rd_chk(input string tag, input logic [31:0] a, input logic [31:0] exp);
        logic [31:0] v;
        axi_rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic pulse_evt(input int g, input logic [31:0] v);
        @(negedge clk);
        hw_evt[g] = v;
        @(negedge clk);
        hw_evt[g] = '0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R3 reg_q g0", reg_q[0], 32'h0000_00A5);
        check("R3 reg_q g3", reg_q[3], 32'h5A5A_000C);
        check("R3 reg_q g7", reg_q[7], 32'h0000_00FF);
        check("R3 reg_q g4", reg_q[4], 32'h0000_1234);
        rd_chk("R3 read g0", 32'h0, 32'h0000_00A5);
        rd_chk("R3 read g2", 32'h8, 32'h0000_0001);
        rd_chk("R3 read g3 hidden bits zero", 32'hC, 32'h5A5A_0000);
        rd_chk("R7 read g7 hidden", SEC | 32'hC, 32'h0);
    endtask

    task automatic t_region();
        axi_wr(32'h0, 32'h1111_1111, 4'hF, 0);
        axi_wr(SEC, 32'h2222_2222, 4'hF, 0);
        rd_chk("R1 primary g0", 32'h0, 32'h1111_1111);
        rd_chk("R1 secondary g4", SEC, 32'h2222_2222);
    endtask

    task automatic t_nofilter();
        axi_wr(32'hE000_0000, 32'h3333_3333, 4'hF, 0);
        rd_chk("R2 high bits reach g0", 32'h0, 32'h3333_3333);
        rd_chk("R2 g4 untouched", SEC, 32'h2222_2222);
        rd_chk("R2 high bits reach g4", 32'hF000_0000, 32'h2222_2222);
        rd_chk("R2 low bits ignored", 32'h0000_0003, 32'h3333_3333);
    endtask

    task automatic t_ro();
        @(negedge clk);
        hw_ro[5] = 32'hCAFE_F00D;
        axi_wr(SEC | 32'h4, 32'hFFFF_FFFF, 4'hF, 0);
        rd_chk("R4 ro ignores write", SEC | 32'h4, 32'hCAFE_F00D);
        @(negedge clk);
        hw_ro[5] = 32'h0123_4567;
        rd_chk("R4 ro tracks hw", SEC | 32'h4, 32'h0123_4567);
    endtask

    task automatic t_rw1c();
        @(negedge clk);
        hw_ro[1] = 32'hABCD_0000;
        pulse_evt(1, 32'h0000_000F);
        rd_chk("R5 hw set", 32'h4, 32'hABCD_000F);
        axi_wr(32'h4, 32'h0000_0005, 4'hF, 0);
        rd_chk("R5 write 1 clears", 32'h4, 32'hABCD_000A);
        axi_wr(32'h4, 32'h0000_0000, 4'hF, 0);
        rd_chk("R5 write 0 keeps", 32'h4, 32'hABCD_000A);
    endtask

    task automatic t_rwc();
        pulse_evt(2, 32'h0000_F0F0);
        rd_chk("R6 hw set", 32'h8, 32'h0000_F0F1);
        axi_wr(32'h8, 32'h0000_0000, 4'hF, 0);
        rd_chk("R6 any write clears", 32'h8, 32'h0);
    endtask

    task automatic t_w1c();
        axi_wr(SEC | 32'hC, 32'h0000_000F, 4'hF, 0);
        @(negedge clk);
        check("R7 write 1 clears", reg_q[7], 32'h0000_00F0);
        axi_wr(SEC | 32'hC, 32'h0000_0000, 4'hF, 0);
        @(negedge clk);
        check("R7 write 0 keeps", reg_q[7], 32'h0000_00F0);
        rd_chk("R7 reads zero", SEC | 32'hC, 32'h0);
        axi_wr(32'hC, 32'h0000_0004, 4'h1, 0);
        @(negedge clk);
        check("R7 g3 hidden clear", reg_q[3], 32'h5A5A_0008);
    endtask

    task automatic t_w1s();
        axi_wr(SEC | 32'h8, 32'h0000_0081, 4'hF, 0);
        @(negedge clk);
        check("R8 write 1 sets", reg_q[6], 32'h0000_0081);
        rd_chk("R8 reads zero", SEC | 32'h8, 32'h0);
        axi_wr(SEC | 32'h8, 32'h0000_0000, 4'hF, 0);
        @(negedge clk);
        check("R8 write 0 keeps", reg_q[6], 32'h0000_0081);
        pulse_evt(6, 32'h0000_0001);
        @(negedge clk);
        check("R8 hw clears", reg_q[6], 32'h0000_0080);
    endtask

    task automatic t_setwins();
        @(negedge clk);
        hw_evt[1] = 32'h0000_0010;
        hw_evt[7] = 32'h0000_0001;
        axi_wr(32'h4, 32'h0000_0010, 4'hF, 0);
        axi_wr(SEC | 32'hC, 32'h0000_0001, 4'hF, 0);
        @(negedge clk);
        hw_evt[1] = '0;
        hw_evt[7] = '0;
        rd_chk("R9 rw1c set wins", 32'h4, 32'hABCD_001A);
        check("R9 w1c set wins", reg_q[7], 32'h0000_00F1);
    endtask

    task automatic t_strobe();
        axi_wr(32'h0, 32'h0000_0000, 4'hF, 0);
        axi_wr(32'h0, 32'hFFFF_FFFF, 4'h2, 0);
        rd_chk("R10 rw lane 1 only", 32'h0, 32'h0000_FF00);
        pulse_evt(1, 32'h0000_FFFF);
        axi_wr(32'h4, 32'h0000_FFFF, 4'h1, 0);
        rd_chk("R10 rw1c lane 0 only", 32'h4, 32'hABCD_FF00);
    endtask

    task automatic t_order();
        axi_wr(SEC, 32'hAAAA_0001, 4'hF, 1);
        rd_chk("R11 address first", SEC, 32'hAAAA_0001);
        axi_wr(SEC, 32'hBBBB_0002, 4'hF, 2);
        rd_chk("R11 data first", SEC, 32'hBBBB_0002);
    endtask

    task automatic t_undef();
        rd_chk("R12 unmapped reads zero", 32'h0000_0010, 32'h0);
        rd_chk("R12 unmapped secondary", SEC | 32'h0FFC, 32'h0);
        axi_wr(32'h0000_0010, 32'hFFFF_FFFF, 4'hF, 0);
        axi_wr(SEC | 32'h0000_0FF8, 32'hFFFF_FFFF, 4'hF, 0);
        rd_chk("R12 write ignored g0", 32'h0, 32'h0000_FF00);
        check("R12 write ignored g6", reg_q[6], 32'h0000_0080);
        check("R12 write ignored g7", reg_q[7], 32'h0000_00F1);
    endtask

    task automatic t_hold();
        bit hs = 0;
        logic [31:0] first;
        s_bready = 1'b0;
        axi_wr(SEC, 32'h5555_0003, 4'hF, 0);
        repeat (3) @(negedge clk);
        check("R13 bvalid held", {31'd0, s_bvalid}, 32'd1);
        s_bready = 1'b1;
        @(negedge clk);
        check("R11 single response", {31'd0, s_bvalid}, 32'd0);
        s_rready = 1'b0;
        while (!hs) begin
            s_araddr  = SEC;
            s_arvalid = 1'b1;
            hs = s_arready;
            @(posedge clk);
            @(negedge clk);
        end
        s_arvalid = 1'b0;
        first = s_rdata;
        repeat (3) @(negedge clk);
        check("R13 rvalid held", {31'd0, s_rvalid}, 32'd1);
        check("R13 rdata stable", s_rdata, first);
        check("R13 rdata value", s_rdata, 32'h5555_0003);
        s_rready = 1'b1;
        @(negedge clk);
        check("R13 rvalid drops", {31'd0, s_rvalid}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_region();
        t_nofilter();
        t_ro();
        t_rw1c();
        t_rwc();
        t_w1c();
        t_w1s();
        t_setwins();
        t_strobe();
        t_order();
        t_undef();
        t_hold();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule